// File: doc/BRIEF.md
# Shared-Bus Module Select Sequencer

Several pluggable transceiver modules hang on one 2-wire management bus, and each listens only while its own active-low select line is held low. This block owns those select lines. A client places a module index on the request port and pulses the request. The block then gives the bus to that module, and it keeps the settle windows that each module needs around a change of select. Once the bus is safe to use, the block raises a grant. The client runs its 2-wire transaction and then pulses done to hand the bus back.

When the block switches from one module to another, it first releases the old select. In the default sequential mode it waits out the release window and only then drives the new select low. It then waits the select window before it grants. An optional overlapped mode drops the old select and drives the new one on the same edge. It then waits for whichever of the two windows is longer, which still meets both timing rules. A request for the module that is already selected is granted at once. An index past the last module is rejected with a one-cycle error pulse and leaves the select lines as they were. Requests that arrive while the block is busy are ignored.

Top module: `bus_select_seq`

## Requirements
- R1: While reset is asserted and just after it, every select line is high, and grant, busy and error are low.
- R2: At most one select line is low at any time.
- R3: When no module is selected, a request for valid index k drives bit k of the select vector low one cycle after the request. Grant rises exactly T_ASSERT cycles after that select edge.
- R4: In sequential mode, a request for a valid index other than the selected one drives all select lines high for T_DEASSERT cycles, then drives the new line low. Grant follows T_ASSERT cycles after the new line falls.
- R5: In overlapped mode, a switch releases the old line and asserts the new line on the same edge. Grant follows max(T_ASSERT, T_DEASSERT) cycles after that edge.
- R6: A request for the module that is already selected raises grant one cycle later, and the select vector does not change.
- R7: A request with an index of NUM_MOD or more produces a one-cycle error pulse on the following cycle. Select lines, grant and busy stay unchanged.
- R8: Grant stays high until done is sampled high and falls on the next cycle. The select line of the granted module stays low afterwards.
- R9: A request sampled while busy is high has no effect on select lines, grant or timing.
- R10: Busy is high from the cycle after a request is accepted until the cycle in which grant falls, and grant is never high while busy is low.
- R11: Grant never rises unless the selected line has been low for at least T_ASSERT cycles and no line has risen within the last T_DEASSERT cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, sampled while idle |
| idx_i | input | IDX_W | Index of the requested module |
| done_i | input | 1 | Transaction-complete pulse from the 2-wire engine |
| sel_n_o | output | NUM_MOD | Active-low select line per module |
| grant_o | output | 1 | Bus may carry traffic for the selected module |
| busy_o | output | 1 | A request is in progress or the bus is granted |
| err_o | output | 1 | One-cycle pulse for an out-of-range index |

## Verification
The checker assumes that the client pulses done only while it holds a grant, and that it does not keep a bad index asserted for consecutive idle cycles. The error-pulse check reads a sustained bad request as a held error. The bench drives every request as a single-cycle strobe and waits for grant before it pulses done. The one extra request it sends while a transaction is pending is deliberately placed in a busy cycle, so that the ignore rule is exercised without breaking those assumptions. Every ordered pair of indices, out-of-range values included, runs through a sequential-mode instance and an overlapped-mode instance that share the same stimulus.

// File: rtl/bss_pkg.sv
package bss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DROP   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_OWN    = 2'd3
    } bss_state_e;

    function automatic int unsigned bss_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bss_idx_decode.sv
module bss_idx_decode #(
    parameter int NUM_MOD = 5,
    parameter int IDX_W   = 3
) (
    input  logic [IDX_W-1:0]   idx,
    output logic               in_range,
    output logic [NUM_MOD-1:0] onehot
);
    localparam logic [31:0] LIMIT = 32'(NUM_MOD);

    assign in_range = ({{(32-IDX_W){1'b0}}, idx} < LIMIT);

    for (genvar i = 0; i < NUM_MOD; i++) begin : g_bit
        assign onehot[i] = (idx == IDX_W'(i));
    end
endmodule

// File: rtl/bss_switch_plan.sv
module bss_switch_plan #(
    parameter int T_ASSERT      = 4,
    parameter int T_DEASSERT    = 3,
    parameter bit OVERLAP       = 1'b0,
    parameter int CNT_W         = 3
) (
    output logic             assert_now,
    output logic [CNT_W-1:0] first_load,
    output bss_pkg::bss_state_e first_state
);
    import bss_pkg::*;
    localparam int unsigned LONGEST = bss_max(T_ASSERT, T_DEASSERT);

    if (OVERLAP) begin : g_overlap
        assign assert_now  = 1'b1;
        assign first_load  = CNT_W'(LONGEST - 1);
        assign first_state = ST_SETTLE;
    end else begin : g_serial
        assign assert_now  = 1'b0;
        assign first_load  = CNT_W'(T_DEASSERT - 1);
        assign first_state = ST_DROP;
    end
endmodule

// File: rtl/bus_select_seq.sv
module bus_select_seq #(
    parameter int NUM_MOD    = 5,
    parameter int IDX_W      = 3,
    parameter int T_ASSERT   = 4,
    parameter int T_DEASSERT = 3,
    parameter bit OVERLAP    = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               done_i,
    output logic [NUM_MOD-1:0] sel_n_o,
    output logic               grant_o,
    output logic               busy_o,
    output logic               err_o
);
    import bss_pkg::*;

    localparam int unsigned LONGEST = bss_max(T_ASSERT, T_DEASSERT);
    localparam int CNT_W = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] A_LOAD = CNT_W'(T_ASSERT - 1);

    typedef struct packed {
        bss_state_e         st;
        logic [IDX_W-1:0]   cur;
        logic               have;
        logic [NUM_MOD-1:0] sel_n;
        logic [CNT_W-1:0]   cnt;
        logic               grant;
        logic               err;
    } regs_t;

    regs_t r_d, r_q;

    logic               req_ok;
    logic [NUM_MOD-1:0] req_oh;
    logic               cur_ok;
    logic [NUM_MOD-1:0] cur_oh;
    logic               sw_assert_now;
    logic [CNT_W-1:0]   sw_load;
    bss_state_e         sw_state;

    bss_idx_decode #(.NUM_MOD(NUM_MOD), .IDX_W(IDX_W)) req_dec_i (
        .idx(idx_i), .in_range(req_ok), .onehot(req_oh)
    );

    bss_idx_decode #(.NUM_MOD(NUM_MOD), .IDX_W(IDX_W)) cur_dec_i (
        .idx(r_q.cur), .in_range(cur_ok), .onehot(cur_oh)
    );

    bss_switch_plan #(
        .T_ASSERT(T_ASSERT), .T_DEASSERT(T_DEASSERT),
        .OVERLAP(OVERLAP), .CNT_W(CNT_W)
    ) plan_i (
        .assert_now(sw_assert_now), .first_load(sw_load), .first_state(sw_state)
    );

    always_comb begin
        r_d     = r_q;
        r_d.err = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    if (!req_ok) begin
                        r_d.err = 1'b1;
                    end else if (r_q.have && (idx_i == r_q.cur)) begin
                        r_d.grant = 1'b1;
                        r_d.st    = ST_OWN;
                    end else begin
                        r_d.cur  = idx_i;
                        r_d.have = 1'b1;
                        if (!r_q.have) begin
                            r_d.sel_n = ~req_oh;
                            r_d.cnt   = A_LOAD;
                            r_d.st    = ST_SETTLE;
                        end else begin
                            r_d.sel_n = sw_assert_now ? ~req_oh : '1;
                            r_d.cnt   = sw_load;
                            r_d.st    = sw_state;
                        end
                    end
                end
            end
            ST_DROP: begin
                if (r_q.cnt == '0) begin
                    r_d.sel_n = cur_ok ? ~cur_oh : '1;
                    r_d.cnt   = A_LOAD;
                    r_d.st    = ST_SETTLE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_SETTLE: begin
                if (r_q.cnt == '0) begin
                    r_d.grant = 1'b1;
                    r_d.st    = ST_OWN;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_OWN: begin
                if (done_i) begin
                    r_d.grant = 1'b0;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.cur   <= '0;
            r_q.have  <= 1'b0;
            r_q.sel_n <= '1;
            r_q.cnt   <= '0;
            r_q.grant <= 1'b0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_n_o = r_q.sel_n;
    assign grant_o = r_q.grant;
    assign busy_o  = (r_q.st != ST_IDLE);
    assign err_o   = r_q.err;
endmodule

// File: rtl/bss_chk.sv
module bss_chk #(
    parameter int NUM_MOD    = 5,
    parameter int T_ASSERT   = 4,
    parameter int T_DEASSERT = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               done_i,
    input logic [NUM_MOD-1:0] sel_n_o,
    input logic               grant_o,
    input logic               busy_o,
    input logic               err_o
);
    localparam int AW = $clog2(T_ASSERT + T_DEASSERT + 2) + 1;
    localparam logic [AW-1:0] AGE_MAX = '1;

    logic [NUM_MOD-1:0] prev_sel_q;
    logic [AW-1:0]      low_age_q;
    logic [AW-1:0]      rise_age_q;
    logic               any_rise;
    logic               changed;

    assign any_rise = |(sel_n_o & ~prev_sel_q);
    assign changed  = (sel_n_o != prev_sel_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sel_q <= '1;
            low_age_q  <= '0;
            rise_age_q <= AGE_MAX;
        end else begin
            prev_sel_q <= sel_n_o;
            if (changed) low_age_q <= '0;
            else if (low_age_q != AGE_MAX) low_age_q <= low_age_q + 1'b1;
            if (any_rise) rise_age_q <= '0;
            else if (rise_age_q != AGE_MAX) rise_age_q <= rise_age_q + 1'b1;
        end
    end

    // R2
    one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n_o));

    // R11
    assert_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_o) |-> (32'(low_age_q) + 1 >= 32'(T_ASSERT)));

    // R11
    deassert_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_o) |-> (32'(rise_age_q) + 1 >= 32'(T_DEASSERT)));

    // R8
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && !done_i) |=> grant_o);

    // R8
    grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && done_i) |=> (!grant_o && $stable(sel_n_o)));

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && !grant_o && $stable(sel_n_o)));

    // R7
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R10
    grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> busy_o);
endmodule

bind bus_select_seq bss_chk #(
    .NUM_MOD(NUM_MOD), .T_ASSERT(T_ASSERT), .T_DEASSERT(T_DEASSERT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .done_i(done_i), .sel_n_o(sel_n_o),
    .grant_o(grant_o), .busy_o(busy_o), .err_o(err_o)
);

// File: tb/bus_select_seq_tb_top.sv
module bus_select_seq_tb_top;
    localparam int N     = 5;
    localparam int IW    = 3;
    localparam int SA    = 4;
    localparam int SD    = 3;
    localparam int OA    = 3;
    localparam int OD    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [IW-1:0] idx = '0;
    logic done = 1'b0;

    logic [N-1:0] s_sel, o_sel;
    logic s_gnt, s_busy, s_err, o_gnt, o_busy, o_err;

    int n_run = 0;
    int n_fail = 0;
    int cur = -1;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bus_select_seq #(.NUM_MOD(N), .IDX_W(IW), .T_ASSERT(SA), .T_DEASSERT(SD), .OVERLAP(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .idx_i(idx), .done_i(done),
        .sel_n_o(s_sel), .grant_o(s_gnt), .busy_o(s_busy), .err_o(s_err));

    bus_select_seq #(.NUM_MOD(N), .IDX_W(IW), .T_ASSERT(OA), .T_DEASSERT(OD), .OVERLAP(1'b1)) dut_ov_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .idx_i(idx), .done_i(done),
        .sel_n_o(o_sel), .grant_o(o_gnt), .busy_o(o_busy), .err_o(o_err));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] sel_of(input int k);
        logic [N-1:0] v = '1;
        if (k >= 0) v[k] = 1'b0;
        return v;
    endfunction

    task automatic run_txn(input int k);
        int ls, lo, lmax, prev;
        logic [N-1:0] old_v, new_v, exp_s;
        prev  = cur;
        old_v = sel_of(prev);
        @(negedge clk);
        req = 1'b1;
        idx = IW'(k);
        @(negedge clk);
        req = 1'b0;
        if (k >= N) begin
            // R7: error pulse, nothing else moves
            for (int s = 1; s <= 3; s++) begin
                check("R7 seq err", 32'(s_err), 32'(s == 1));
                check("R7 ov err", 32'(o_err), 32'(s == 1));
                check("R7 seq sel", 32'(s_sel), 32'(old_v));
                check("R7 ov sel", 32'(o_sel), 32'(old_v));
                check("R7 busy", 32'({s_busy, o_busy, s_gnt, o_gnt}), 0);
                @(negedge clk);
            end
            return;
        end
        new_v = sel_of(k);
        if (prev == k) begin ls = 0; lo = 0; end
        else if (prev < 0) begin ls = SA; lo = OA; end
        else begin ls = SD + SA; lo = (OA > OD) ? OA : OD; end
        lmax = (ls > lo) ? ls : lo;
        for (int s = 1; s <= lmax + 3; s++) begin
            // R3 R4 R6: sequential-mode select pattern
            exp_s = (prev >= 0 && prev != k && s <= SD) ? '1 : new_v;
            check("R4 seq sel", 32'(s_sel), 32'(exp_s));
            // R5: overlapped select switches at once
            check("R5 ov sel", 32'(o_sel), 32'(new_v));
            check("R3 seq grant", 32'(s_gnt), 32'(s >= ls + 1));
            check("R5 ov grant", 32'(o_gnt), 32'(s >= lo + 1));
            // R10
            check("R10 busy", 32'({s_busy, o_busy}), 2'b11);
            check("R7 no err", 32'({s_err, o_err}), 0);
            // R9: one stray request while busy
            if (s == 1) begin
                req = 1'b1;
                idx = IW'((k + 1) % N);
            end else begin
                req = 1'b0;
            end
            @(negedge clk);
        end
        // R8: done ends grant, select stays
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        check("R8 grant drop", 32'({s_gnt, o_gnt}), 0);
        check("R8 sel kept", 32'(s_sel), 32'(new_v));
        check("R8 ov sel kept", 32'(o_sel), 32'(new_v));
        check("R10 idle", 32'({s_busy, o_busy}), 0);
        cur = k;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check("R1 sel", 32'(s_sel), 32'({N{1'b1}}));
        check("R1 ov sel", 32'(o_sel), 32'({N{1'b1}}));
        check("R1 flags", 32'({s_gnt, s_busy, s_err, o_gnt, o_busy, o_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after", 32'({s_gnt, s_busy, s_err, o_gnt, o_busy, o_err}), 0);
        // R7 before any select, then all ordered pairs
        run_txn(7);
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                run_txn(a);
                run_txn(b);
            end
        end
        finished = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule